// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block picks the address of the next microinstruction for a microprogrammed control unit. It holds the control address register that drives the read address of the control memory. While the present microinstruction's operations run, the block forms the next address from that microinstruction's sequencing code, condition select and address field. It then loads that address into the register on the clock edge, ready for the following control-memory read.

There are four sources for the next address:
- the present address plus one;
- the microinstruction's address field;
- a routine start address built from the instruction opcode;
- a one-entry return register that a subroutine call fills.

A condition select picks one status bit, a constant true, or a constant false. This lets the same code perform conditional branches, unconditional branches, and conditional calls.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the control address to 0, the start of the fetch routine, and clears the return register to 0.
- R2: With sequencing code 2'b00 and a condition that is false, the next control address is the present address plus one. The sum wraps modulo 2^ADDR_W, so 255 goes to 0 at default width.
- R3: Condition select value 0 is always true. Value k from 1 to STAT_W picks status[k-1]. Any value above STAT_W is always false.
- R4: With sequencing code 2'b00 and a true condition, the next control address is the branch address field.
- R5: Sequencing code 2'b01 loads the opcode shifted left by MAP_SHIFT (2 by default), with zeros in every other bit. This gives each opcode a four-word routine slot. The condition and the branch field have no effect.
- R6: Sequencing code 2'b10 with a true condition loads the branch field and saves the present address plus one in the return register. With a false condition it only increments, and the return register keeps its value.
- R7: Sequencing code 2'b11 loads the return register into the control address, whatever the condition. The return register keeps its value.
- R8: A new address appears on car exactly one clock edge after the inputs that select it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_op | input | 2 | Sequencing code: 00 cond branch, 01 map, 10 call, 11 return |
| cond_sel | input | SEL_W (3) | Condition select: 0 true, 1..STAT_W status bit, above false |
| br_addr | input | ADDR_W (8) | Branch / call target field of the current microinstruction |
| opcode | input | OPC_W (4) | Instruction opcode bits used by the mapping |
| status | input | STAT_W (4) | Status flags from the datapath |
| car | output | ADDR_W (8) | Control address register, the control-memory read address |

## Verification
Some properties are checked on every cycle:
- a false-condition step increments the address;
- a true-condition branch or call lands on the branch field;
- a mapped address has zero bits outside the opcode slot;
- a call saves the old address plus one;
- a return lands on the saved value.

The bench's scenarios are what show the rest:
- that each condition-select value reaches the right status bit;
- the wrap from the top address to 0;
- that a return issued before any call goes to 0;
- that reset in mid-routine clears both registers;
- that a call with a false condition leaves the saved address untouched.

A long run of random codes, compared every cycle against a behavioural model, covers the mixed orderings of these cases.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEQ_COND = 2'b00,
    SEQ_MAP  = 2'b01,
    SEQ_CALL = 2'b10,
    SEQ_RET  = 2'b11
  } seq_op_e;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int STAT_W = 4,
  parameter int SEL_W  = $clog2(STAT_W + 1)
) (
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [STAT_W-1:0] status,
  output logic              cond_true
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0] choice;

  // Slot 0 is constant true, slots 1..STAT_W carry status, the rest are false.
  for (genvar i = 0; i < NSEL; i++) begin : g_choice
    if (i == 0) begin : g_true
      assign choice[i] = 1'b1;
    end else if (i <= STAT_W) begin : g_stat
      assign choice[i] = status[i-1];
    end else begin : g_false
      assign choice[i] = 1'b0;
    end
  end

  assign cond_true = choice[cond_sel];
endmodule

// File: rtl/useq_map.sv
module useq_map #(
  parameter int ADDR_W    = 8,
  parameter int OPC_W     = 4,
  parameter int MAP_SHIFT = 2
) (
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] map_addr
);
  logic [ADDR_W-1:0] opc_ext;

  assign opc_ext  = ADDR_W'(opcode);
  assign map_addr = opc_ext << MAP_SHIFT;
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        seq_op,
  input  logic              cond_true,
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [ADDR_W-1:0] ret_q,
  output logic [ADDR_W-1:0] car_next,
  output logic [ADDR_W-1:0] ret_next,
  output logic              ret_load
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] car_inc;

  assign car_inc  = car + ONE;
  assign ret_next = car_inc;

  always_comb begin
    car_next = car_inc;
    ret_load = 1'b0;
    unique case (seq_op_e'(seq_op))
      SEQ_COND: car_next = cond_true ? br_addr : car_inc;
      SEQ_MAP:  car_next = map_addr;
      SEQ_CALL: begin
        car_next = cond_true ? br_addr : car_inc;
        ret_load = cond_true;
      end
      SEQ_RET:  car_next = ret_q;
      default:  car_next = car_inc;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OPC_W     = 4,
  parameter int STAT_W    = 4,
  parameter int MAP_SHIFT = 2,
  parameter int SEL_W     = $clog2(STAT_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        seq_op,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [STAT_W-1:0] status,
  output logic [ADDR_W-1:0] car
);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SLOT_MSK = ADDR_W'(((1 << OPC_W) - 1) << MAP_SHIFT);

  logic              cond_true;
  logic [ADDR_W-1:0] map_addr;
  logic [ADDR_W-1:0] car_next;
  logic [ADDR_W-1:0] ret_next;
  logic              ret_load;
  logic [ADDR_W-1:0] ret_q;

  useq_cond_mux #(.STAT_W(STAT_W), .SEL_W(SEL_W)) u_cond (
    .cond_sel (cond_sel),
    .status   (status),
    .cond_true(cond_true)
  );

  useq_map #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_SHIFT(MAP_SHIFT)) u_map (
    .opcode  (opcode),
    .map_addr(map_addr)
  );

  useq_next_sel #(.ADDR_W(ADDR_W)) u_sel (
    .seq_op   (seq_op),
    .cond_true(cond_true),
    .car      (car),
    .br_addr  (br_addr),
    .map_addr (map_addr),
    .ret_q    (ret_q),
    .car_next (car_next),
    .ret_next (ret_next),
    .ret_load (ret_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car   <= '0;
      ret_q <= '0;
    end else begin
      car <= car_next;
      if (ret_load) ret_q <= ret_next;
    end
  end

  // R2: a false condition on a branch or call advances by one.
  a_r2_incr_on_false: assert property (@(posedge clk) disable iff (rst)
    ((seq_op == SEQ_COND || seq_op == SEQ_CALL) && !cond_true) |=> (car == $past(car) + ONE));

  // R4: a true branch lands on the branch field.
  a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (seq_op == SEQ_COND && cond_true) |=> (car == $past(br_addr)));

  // R5: a mapped address has no bits set outside the opcode slot.
  a_r5_map_slot: assert property (@(posedge clk) disable iff (rst)
    (seq_op == SEQ_MAP) |=> ((car & ~SLOT_MSK) == '0));

  // R6: a taken call jumps and saves the old address plus one.
  a_r6_call_save: assert property (@(posedge clk) disable iff (rst)
    (seq_op == SEQ_CALL && cond_true) |=> (ret_q == $past(car) + ONE && car == $past(br_addr)));

  // R7: a return lands on the saved address and leaves it in place.
  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    (seq_op == SEQ_RET) |=> (car == $past(ret_q) && $stable(ret_q)));
endmodule

// File: tb/useq_sequencer_tb.sv
`timescale 1ns/1ps
module useq_sequencer_tb;
  localparam int ADDR_W = 8;
  localparam int OPC_W  = 4;
  localparam int STAT_W = 4;
  localparam int SEL_W  = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        seq_op;
  logic [SEL_W-1:0]  cond_sel;
  logic [ADDR_W-1:0] br_addr;
  logic [OPC_W-1:0]  opcode;
  logic [STAT_W-1:0] status;
  logic [ADDR_W-1:0] car;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int m_car = 0;
  int m_ret = 0;

  always #4 clk = ~clk;

  useq_sequencer u_dut (
    .clk(clk), .rst(rst), .seq_op(seq_op), .cond_sel(cond_sel),
    .br_addr(br_addr), .opcode(opcode), .status(status), .car(car)
  );

  function automatic bit model_cond(int sel, logic [STAT_W-1:0] st);
    if (sel == 0) return 1'b1;
    if (sel <= STAT_W) return st[sel-1];
    return 1'b0;
  endfunction

  task automatic check(string tag, int expv);
    checks++;
    if (int'(car) != expv) begin
      failures++;
      $display("FAIL %s car=%0d expected=%0d", tag, car, expv);
    end
  endtask

  // Drive one microinstruction at the falling edge, update model, check at next falling edge.
  task automatic step(string tag, int op, int sel, int br, int opc, int st);
    bit t;
    int nxt;
    seq_op = 2'(op); cond_sel = SEL_W'(sel); br_addr = ADDR_W'(br);
    opcode = OPC_W'(opc); status = STAT_W'(st);
    t = model_cond(sel, STAT_W'(st));
    nxt = (m_car + 1) % 256;
    case (op)
      0: if (t) nxt = br;
      1: nxt = opc * 4;
      2: if (t) begin m_ret = (m_car + 1) % 256; nxt = br; end
      default: nxt = m_ret;
    endcase
    m_car = nxt;
    @(negedge clk);
    check(tag, m_car);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_car = 0; m_ret = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    seq_op = 0; cond_sel = 0; br_addr = 0; opcode = 0; status = 0;
    @(negedge clk);
    do_reset();
    check("R1 reset", 0);
    // R2 increment with never-true select, and the wrap
    step("R2 incr", 0, 5, 99, 0, 15);
    step("R2 incr", 0, 7, 99, 0, 15);
    step("R4 branch always", 0, 0, 254, 0, 0);
    step("R2 incr to 255", 0, 6, 0, 0, 15);
    step("R2 wrap", 0, 5, 0, 0, 15);
    // R3 each status bit, true then false
    for (int k = 1; k <= STAT_W; k++) begin
      step("R3 sel true", 0, k, 16 * k, 0, 1 << (k - 1));
      step("R3 sel false", 0, k, 200, 0, 15 & ~(1 << (k - 1)));
    end
    // R5 mapping, condition and branch ignored
    step("R5 map", 1, 0, 77, 15, 15);
    step("R5 map", 1, 6, 3, 1, 0);
    step("R5 map", 1, 2, 250, 9, 2);
    // R7 return before any call gives reset value
    do_reset();
    step("R7 ret after reset", 3, 0, 55, 0, 0);
    // R6 call taken then return
    step("R4 branch", 0, 0, 40, 0, 0);
    step("R6 call", 2, 1, 120, 0, 1);
    step("R2 in sub", 0, 5, 0, 0, 0);
    step("R6 call false", 2, 2, 9, 0, 0);
    step("R7 return", 3, 5, 0, 0, 0);
    step("R7 return again", 3, 0, 0, 0, 0);
    // R1 reset mid-run clears return register
    step("R6 call", 2, 0, 180, 0, 0);
    do_reset();
    check("R1 reset mid", 0);
    step("R1 ret cleared", 3, 0, 0, 0, 0);
    // R8 random stream, one-edge latency against the model
    for (int i = 0; i < 400; i++) begin
      step("R8 random", int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule